// File: doc/BRIEF.md
# I2C Slave Address Status Monitor

This block sits beside an I2C slave and watches its SCL and SDA lines, which arrive already synchronised to the system clock. It finds start and stop conditions and shifts in the first byte that follows each start. In address-recognition mode it compares that byte with a programmable 7-bit own address and also spots the general-call address. In free-data mode it takes the first byte after a start as data. It keeps three status flags for a processor: address matched, general call seen, and last received bit.

Software configures the block with one write strobe that loads the own address, the mode and the I2C enable. A data-buffer access strobe tells the monitor that software has read or written the data buffer. A two-write key on a 2-bit reset field puts the monitor back in its reset state. That state is port mode, where the bus is ignored. A one-cycle event pulse marks the end of each address byte.

Top module: `i2c_addr_monitor`

## Requirements
- R1: After `rst`, all of these read 0: `addr_match`, `gen_call`, `last_bit`, `addr_done`, `i2c_mode` and `swrst_field`. A value of 0 on `i2c_mode` means port mode.
- R2: A start is SDA falling while SCL is high. The 8 bits that follow it are taken most significant bit first, one on each SCL rise. On the 8th rise `addr_done` goes high for exactly one cycle, the cycle after that rise is registered. In address mode, `addr_match` sets in that same cycle when bits 7..1 equal the own address. Bit 0 is the direction bit and is left out of this compare.
- R3: In address mode, if the address differs and the byte is not a general call, `addr_match` stays 0. `addr_done` still pulses.
- R4: In address mode, a first byte of 8'h00 sets both `addr_match` and `gen_call`. A byte of 8'h01 is not a general call. It matches only if the own address is 0.
- R5: In free-data mode (`cfg_free_mode`=1), any first byte sets `addr_match` and never sets `gen_call`.
- R6: A pulse on `buf_access` clears `addr_match` one cycle later. If it arrives in the same cycle as a setting byte end, the set wins.
- R7: `buf_access` does not affect `gen_call`. It is cleared only by a start or a stop (SDA rising while SCL is high), or by a reset.
- R8: In I2C mode, `last_bit` takes the SDA value at every SCL rise. In port mode, SCL and SDA change no output.
- R9: Only the first byte after a start is examined. Later bytes in the same transfer do not pulse `addr_done` and do not set any flag.
- R10: Write 2'b10 to the reset field, then write 2'b01 as the very next write. One cycle later, every flag, the configuration (own address 0, address mode, port mode) and `swrst_field` are all 0.
- R11: Any other write breaks the key sequence. A 2'b01 that does not directly follow a 2'b10 does not reset the block. `swrst_field` shows the value last written unless the reset fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Synchronised SCL sample |
| sda_in | input | 1 | Synchronised SDA sample |
| cfg_wr | input | 1 | Loads the three configuration inputs |
| cfg_own_addr | input | 7 | Own 7-bit slave address |
| cfg_free_mode | input | 1 | 1 selects free-data mode, 0 selects address recognition |
| cfg_i2c_en | input | 1 | 1 selects I2C mode, 0 selects port mode |
| key_wr | input | 1 | Write strobe for the reset field |
| key_wdata | input | 2 | Value written to the reset field |
| buf_access | input | 1 | Data buffer read or write pulse |
| addr_match | output | 1 | Address-matched flag |
| gen_call | output | 1 | General-call flag |
| last_bit | output | 1 | Last SDA bit sampled on an SCL rise |
| i2c_mode | output | 1 | 1 when I2C mode is active |
| addr_done | output | 1 | One-cycle pulse at the end of an address byte |
| swrst_field | output | 2 | Current reset field value |

## Verification
A wrong bit count or a shift register that never clears shows first as `addr_done` pulsing on the wrong SCL rise. The same fault then shows as a wrong flag one cycle after the 8th rise of the address byte. A key state left set by mistake shows only two writes later, when a reset fires that should not, or fails to fire when it should. Missing clear paths for `gen_call` and `addr_match` show in the cycle after the start, stop or buffer access that should have cleared them.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = ADDR_W + 1;
    localparam int KEY_W  = 2;

    typedef struct packed {
        logic [ADDR_W-1:0] own_addr;
        logic              free_mode;
        logic              i2c_en;
    } cfg_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic byte_done;
    } bus_evt_t;

    typedef enum logic [KEY_W-1:0] {
        KEY_ARM  = 2'b10,
        KEY_FIRE = 2'b01
    } key_code_e;

    function automatic logic is_general_call(input logic [BYTE_W-1:0] b);
        return b == '0;
    endfunction

    function automatic logic own_hit(input logic [BYTE_W-1:0] b,
                                     input logic [ADDR_W-1:0] a);
        return b[BYTE_W-1:1] == a;
    endfunction
endpackage

// File: rtl/i2cmon_bus_events.sv
module i2cmon_bus_events
    import i2cmon_pkg::*;
#(
    parameter int NBITS = BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             scl,
    input  logic             sda,
    output bus_evt_t         evt,
    output logic [NBITS-1:0] rx_byte
);
    localparam int CNT_W = $clog2(NBITS);

    logic             scl_q, sda_q;
    logic             in_addr;
    logic [CNT_W-1:0] bit_cnt;
    logic [NBITS-1:0] shreg;

    always_comb begin
        evt.start     = enable && scl && scl_q && sda_q && !sda;
        evt.stop      = enable && scl && scl_q && !sda_q && sda;
        evt.scl_rise  = enable && scl && !scl_q;
        evt.byte_done = evt.scl_rise && in_addr && (bit_cnt == CNT_W'(NBITS-1));
        rx_byte       = {shreg[NBITS-2:0], sda};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q   <= 1'b1;
            sda_q   <= 1'b1;
            in_addr <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
            if (!enable) begin
                in_addr <= 1'b0;
                bit_cnt <= '0;
            end else if (evt.start) begin
                in_addr <= 1'b1;
                bit_cnt <= '0;
            end else if (evt.stop) begin
                in_addr <= 1'b0;
            end else if (evt.scl_rise && in_addr) begin
                shreg   <= rx_byte;
                bit_cnt <= bit_cnt + 1'b1;
                if (evt.byte_done)
                    in_addr <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/i2cmon_key_reset.sv
module i2cmon_key_reset
    import i2cmon_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [KEY_W-1:0] wdata,
    output logic             fire,
    output logic [KEY_W-1:0] field
);
    logic armed;

    assign fire = wr && armed && (wdata == KEY_FIRE);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed <= 1'b0;
            field <= '0;
        end else if (wr) begin
            if (fire) begin
                armed <= 1'b0;
                field <= '0;
            end else begin
                armed <= (wdata == KEY_ARM);
                field <= wdata;
            end
        end
    end
endmodule

// File: rtl/i2cmon_flags.sv
module i2cmon_flags
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              sda,
    input  logic              buf_access,
    output logic              addr_match,
    output logic              gen_call,
    output logic              last_bit,
    output logic              addr_done
);
    logic gc_seen, hit;

    always_comb begin
        gc_seen = !cfg.free_mode && is_general_call(rx_byte);
        hit     = cfg.free_mode || gc_seen || own_hit(rx_byte, cfg.own_addr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_match <= 1'b0;
            gen_call   <= 1'b0;
            last_bit   <= 1'b0;
            addr_done  <= 1'b0;
        end else begin
            addr_done <= evt.byte_done;
            if (evt.scl_rise)
                last_bit <= sda;
            if (evt.byte_done && hit)
                addr_match <= 1'b1;
            else if (buf_access)
                addr_match <= 1'b0;
            if (evt.start || evt.stop)
                gen_call <= 1'b0;
            else if (evt.byte_done && gc_seen)
                gen_call <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_addr_monitor.sv
module i2c_addr_monitor
    import i2cmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_own_addr,
    input  logic              cfg_free_mode,
    input  logic              cfg_i2c_en,
    input  logic              key_wr,
    input  logic [KEY_W-1:0]  key_wdata,
    input  logic              buf_access,
    output logic              addr_match,
    output logic              gen_call,
    output logic              last_bit,
    output logic              i2c_mode,
    output logic              addr_done,
    output logic [KEY_W-1:0]  swrst_field
);
    cfg_t              cfg;
    bus_evt_t          evt;
    logic [BYTE_W-1:0] rx_byte;
    logic              key_fire;
    logic              rst_all;

    assign rst_all  = rst || key_fire;
    assign i2c_mode = cfg.i2c_en;

    always_ff @(posedge clk) begin
        if (rst_all)
            cfg <= '0;
        else if (cfg_wr)
            cfg <= '{own_addr: cfg_own_addr, free_mode: cfg_free_mode, i2c_en: cfg_i2c_en};
    end

    i2cmon_key_reset key_i (
        .clk   (clk),
        .rst   (rst),
        .wr    (key_wr),
        .wdata (key_wdata),
        .fire  (key_fire),
        .field (swrst_field)
    );

    i2cmon_bus_events #(.NBITS(BYTE_W)) bus_i (
        .clk     (clk),
        .rst     (rst_all),
        .enable  (cfg.i2c_en),
        .scl     (scl_in),
        .sda     (sda_in),
        .evt     (evt),
        .rx_byte (rx_byte)
    );

    i2cmon_flags flags_i (
        .clk        (clk),
        .rst        (rst_all),
        .cfg        (cfg),
        .evt        (evt),
        .rx_byte    (rx_byte),
        .sda        (sda_in),
        .buf_access (buf_access),
        .addr_match (addr_match),
        .gen_call   (gen_call),
        .last_bit   (last_bit),
        .addr_done  (addr_done)
    );
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker (
    input logic       clk,
    input logic       rst,
    input logic       evt_start,
    input logic       evt_stop,
    input logic       key_fire,
    input logic       buf_access,
    input logic       addr_done,
    input logic       addr_match,
    input logic       gen_call,
    input logic       last_bit,
    input logic       i2c_mode,
    input logic [1:0] swrst_field
);
    assert_match_at_byte_end_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_match) |-> addr_done);

    assert_gc_implies_match_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(gen_call) |-> (addr_match && addr_done));

    assert_match_clear_source_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(addr_match) |-> $past(buf_access || key_fire || rst));

    assert_gc_clear_source_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(gen_call) |-> $past(evt_start || evt_stop || key_fire || rst));

    assert_port_mode_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!i2c_mode && !key_fire) |=> ($stable(last_bit) && !addr_done));

    assert_soft_reset_clears_R10: assert property (@(posedge clk) disable iff (rst)
        key_fire |=> (swrst_field == 2'b00 && !i2c_mode && !addr_match && !gen_call));
endmodule

bind i2c_addr_monitor i2cmon_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .evt_start   (evt.start),
    .evt_stop    (evt.stop),
    .key_fire    (key_fire),
    .buf_access  (buf_access),
    .addr_done   (addr_done),
    .addr_match  (addr_match),
    .gen_call    (gen_call),
    .last_bit    (last_bit),
    .i2c_mode    (i2c_mode),
    .swrst_field (swrst_field)
);

// File: tb/i2c_addr_monitor_tb_top.sv
module i2c_addr_monitor_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_i = 1'b1, sda_i = 1'b1;
    logic       cfg_wr = 1'b0, cfg_free = 1'b0, cfg_en = 1'b0;
    logic [6:0] cfg_addr = '0;
    logic       key_wr = 1'b0;
    logic [1:0] key_data = '0;
    logic       buf_acc = 1'b0;
    logic       addr_match, gen_call, last_bit, i2c_mode, addr_done;
    logic [1:0] swrst_field;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    i2c_addr_monitor dut_i (
        .clk(clk), .rst(rst), .scl_in(scl_i), .sda_in(sda_i),
        .cfg_wr(cfg_wr), .cfg_own_addr(cfg_addr), .cfg_free_mode(cfg_free),
        .cfg_i2c_en(cfg_en), .key_wr(key_wr), .key_wdata(key_data),
        .buf_access(buf_acc), .addr_match(addr_match), .gen_call(gen_call),
        .last_bit(last_bit), .i2c_mode(i2c_mode), .addr_done(addr_done),
        .swrst_field(swrst_field)
    );

    typedef struct packed {
        logic       free;
        logic [6:0] own;
        logic [7:0] data;
        logic       m;
        logic       g;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 7'h3A, 8'h74, 1'b1, 1'b0},
        '{1'b0, 7'h3A, 8'h75, 1'b1, 1'b0},
        '{1'b0, 7'h3A, 8'h76, 1'b0, 1'b0},
        '{1'b0, 7'h3A, 8'h00, 1'b1, 1'b1},
        '{1'b0, 7'h00, 8'h01, 1'b1, 1'b0},
        '{1'b0, 7'h3A, 8'h01, 1'b0, 1'b0},
        '{1'b1, 7'h3A, 8'h55, 1'b1, 1'b0},
        '{1'b1, 7'h3A, 8'h00, 1'b1, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic d);
        @(negedge clk);
        scl_i = s;
        sda_i = d;
    endtask

    task automatic cfg_write(input logic [6:0] a, input logic f, input logic e);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_free = f; cfg_en = e;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic key_write(input logic [1:0] v);
        @(negedge clk);
        key_wr = 1'b1; key_data = v;
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    task automatic buf_pulse();
        @(negedge clk);
        buf_acc = 1'b1;
        @(negedge clk);
        buf_acc = 1'b0;
    endtask

    task automatic start_cond();
        drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
    endtask

    task automatic stop_cond();
        drive(0, 0); drive(1, 0); drive(1, 1);
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic acc_last, output int dones);
        dones = 0;
        for (int i = 7; i >= 0; i--) begin
            drive(0, b[i]);
            @(negedge clk);
            scl_i = 1'b1;
            buf_acc = (i == 0) && acc_last;
            @(negedge clk);
            buf_acc = 1'b0;
            dones += int'(addr_done);
            scl_i = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 addr_match", addr_match, 0);
        chk("R1 gen_call", gen_call, 0);
        chk("R1 last_bit", last_bit, 0);
        chk("R1 i2c_mode", i2c_mode, 0);
        chk("R1 swrst_field", swrst_field, 0);

        // R8 port mode ignores the bus
        start_cond();
        send_byte(8'h00, 1'b0, d);
        drive(0, 1); drive(1, 1);
        @(negedge clk);
        chk("R8 port mode done pulses", d, 0);
        chk("R8 port mode match", addr_match, 0);
        chk("R8 port mode last_bit", last_bit, 0);
        stop_cond();

        // Vector walk: R2 R3 R4 R5 plus stop clear R7 and access clear R6
        for (int v = 0; v < NVEC; v++) begin
            cfg_write(VECS[v].own, VECS[v].free, 1'b1);
            start_cond();
            send_byte(VECS[v].data, 1'b0, d);
            chk("R2 one done pulse", d, 1);
            chk(VECS[v].free ? "R5 match" : "R2/R3/R4 match", addr_match, VECS[v].m);
            chk(VECS[v].free ? "R5 gen_call" : "R4 gen_call", gen_call, VECS[v].g);
            chk("R8 last_bit", last_bit, VECS[v].data[0]);
            stop_cond();
            chk("R7 stop clears gen_call", gen_call, 0);
            buf_pulse();
            chk("R6 access clears match", addr_match, 0);
        end

        // R6 set wins over a same-cycle access
        cfg_write(7'h3A, 1'b0, 1'b1);
        start_cond();
        send_byte(8'h74, 1'b1, d);
        chk("R6 set wins", addr_match, 1);
        buf_pulse();
        chk("R6 cleared", addr_match, 0);
        // R9 later byte in same transfer is not examined
        send_byte(8'h74, 1'b0, d);
        chk("R9 no done on second byte", d, 0);
        chk("R9 no match on second byte", addr_match, 0);
        stop_cond();

        // R7 gen_call survives access, cleared by repeated start
        start_cond();
        send_byte(8'h00, 1'b0, d);
        buf_pulse();
        chk("R7 gc kept after access", gen_call, 1);
        chk("R6 match cleared with gc", addr_match, 0);
        drive(0, 1); drive(1, 1); drive(1, 0);
        @(negedge clk);
        chk("R7 repeated start clears gc", gen_call, 0);
        drive(0, 0);
        stop_cond();

        // R10 key sequence fires
        start_cond();
        send_byte(8'h74, 1'b0, d);
        key_write(2'b10);
        chk("R10 field after first key", swrst_field, 2);
        chk("R10 flag held before fire", addr_match, 1);
        key_write(2'b01);
        chk("R10 field cleared", swrst_field, 0);
        chk("R10 mode back to port", i2c_mode, 0);
        chk("R10 match cleared", addr_match, 0);
        stop_cond();

        // R11 broken sequences
        cfg_write(7'h3A, 1'b0, 1'b1);
        key_write(2'b01);
        chk("R11 lone second key field", swrst_field, 1);
        chk("R11 lone second key no reset", i2c_mode, 1);
        key_write(2'b10);
        key_write(2'b11);
        key_write(2'b01);
        chk("R11 aborted key no reset", i2c_mode, 1);
        chk("R11 aborted key field", swrst_field, 1);
        key_write(2'b10);
        key_write(2'b10);
        key_write(2'b01);
        chk("R11 restarted key fires", i2c_mode, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule